// File: doc/BRIEF.md
# Interrupt Destination Matcher with Rotating Lowest-Priority Pick

This block takes one inter-processor message request per cycle and decides which of `N_UNITS` local interrupt units should accept it. Each unit presents its own 8-bit physical ID, its own 8-bit logical ID, a destination-format code and an enable bit. The request carries an 8-bit destination, a physical/logical mode bit, a 2-bit shorthand, the index of the unit that sent it, and a lowest-priority flag. The result is a registered accept mask with one bit per unit.

When shorthand is "none", the destination is compared with each unit's physical ID, or it is decoded in flat or cluster logical form. The other three shorthand codes select the sender only, every unit, or every unit except the sender. For lowest-priority requests the block does not compare priorities. It takes the matched set, drops units that are disabled, and picks exactly one unit by round-robin. The search starts one position past the last unit chosen and wraps at `N_UNITS`. The pick is made in a single cycle by rotating the candidate vector and priority-encoding the result.

Top module: `ipi_dest_router`

## Requirements
- R1: After synchronous reset, `acc_valid` and `acc_mask` are 0. The rotating pointer holds `N_UNITS-1`, so the first lowest-priority search begins at unit 0.
- R2: A request sampled with `req_valid`=1 on a rising edge produces `acc_valid`=1 and its mask on that same edge, which is one cycle of latency. `acc_valid` is 0, and `acc_mask` is 0, in every cycle after a cycle with no request.
- R3: With shorthand 0 (none) and `req_logical`=0, unit i matches when `req_dest` equals its physical ID (bits [8i+7:8i] of `unit_id`), or when `req_dest` is 8'hFF.
- R4: With shorthand 0, `req_logical`=1 and unit format 4'hF (flat), unit i matches when its logical ID AND `req_dest` is non-zero.
- R5: With shorthand 0, `req_logical`=1 and unit format 4'h0 (cluster), unit i matches when the upper nibbles of its logical ID and `req_dest` are equal and the AND of their lower nibbles is non-zero.
- R6: A unit whose format code (bits [4i+3:4i] of `unit_fmt`) is neither 4'hF nor 4'h0 never matches in logical mode.
- R7: Shorthand 1 matches only unit `req_src`. Shorthand 2 matches all units. Shorthand 3 matches all units except `req_src`. For codes 1 to 3, `req_dest` and `req_logical` have no effect.
- R8: With `req_lowpri`=1, `acc_mask` has at most one bit set. That bit is the first unit, searching upward from (pointer+1) with wrap at `N_UNITS`, that is both matched and enabled. The unit at the pointer itself is tried last.
- R9: The pointer moves to the chosen unit only when a lowest-priority request finds a winner. A lowest-priority request with no qualifying unit gives mask 0 and leaves the pointer unchanged. Requests that are not lowest-priority never move the pointer.
- R10: `unit_en` has no effect on the mask of requests that are not lowest-priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_dest | input | ID_W | Destination field |
| req_logical | input | 1 | 1 = logical destination mode, 0 = physical |
| req_short | input | 2 | Shorthand: 0 none, 1 self, 2 all, 3 all-but-sender |
| req_lowpri | input | 1 | Lowest-priority delivery: pick one unit |
| req_src | input | IDX_W | Index of the sending unit |
| unit_id | input | N_UNITS*ID_W | Physical ID of each unit, packed by index |
| unit_lid | input | N_UNITS*ID_W | Logical ID of each unit, packed by index |
| unit_fmt | input | N_UNITS*4 | Format per unit: 4'hF flat, 4'h0 cluster |
| unit_en | input | N_UNITS | Unit enabled for lowest-priority selection |
| acc_valid | output | 1 | Result valid |
| acc_mask | output | N_UNITS | Accepting units |

## Verification
The bench targets the physical broadcast value 8'hFF, a cluster decode where the upper nibble must match and the low nibbles must overlap, and a format code that is neither flat nor cluster. A design that gets any of these wrong returns masks that are too wide or too narrow. For the rotating pick, the bench checks the wrap past the last index, skipping a disabled unit, and a lowest-priority request that finds nothing. A pointer that moves on a failed search, or on a request that is not lowest-priority, sends the next pick to the wrong unit. Self and all-but-sender requests are sent with a destination that would match other units, so a design that still decodes the destination on those requests fails.

// File: rtl/ipi_route_pkg.sv
package ipi_route_pkg;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } short_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

endpackage

// File: rtl/ipi_match_unit.sv
module ipi_match_unit
  import ipi_route_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int IDX_W = 3,
  parameter int INDEX = 0
) (
  input  logic [ID_W-1:0]  dest,
  input  logic             logical,
  input  short_e           shorthand,
  input  logic [IDX_W-1:0] src,
  input  logic [ID_W-1:0]  id,
  input  logic [ID_W-1:0]  lid,
  input  logic [3:0]       fmt,
  output logic             hit
);

  localparam int HALF = ID_W / 2;
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(INDEX);

  logic phys_hit, flat_hit, clus_hit, logi_hit;

  assign phys_hit = (dest == id) || (&dest);
  assign flat_hit = |(lid & dest);
  assign clus_hit = (lid[ID_W-1:HALF] == dest[ID_W-1:HALF]) &&
                    (|(lid[HALF-1:0] & dest[HALF-1:0]));

  always_comb begin
    case (fmt)
      FMT_FLAT:    logi_hit = flat_hit;
      FMT_CLUSTER: logi_hit = clus_hit;
      default:     logi_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (shorthand)
      SH_NONE:   hit = logical ? logi_hit : phys_hit;
      SH_SELF:   hit = (src == MY_IDX);
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = (src != MY_IDX);
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] prev,
  output logic             found,
  output logic [IDX_W-1:0] win,
  output logic [N-1:0]     win_mask
);

  localparam int LAST = N - 1;

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a,
                                                input logic [IDX_W-1:0] b);
    logic [IDX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (IDX_W+1)'(N)) s = s - (IDX_W+1)'(N);
    return s[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] start;
  logic [IDX_W-1:0] off;
  logic [N-1:0]     rot;

  assign start = (prev >= IDX_W'(LAST)) ? '0 : prev + 1'b1;

  for (genvar k = 0; k < N; k++) begin : g_rot
    assign rot[k] = cand[wrap_add(start, IDX_W'(k))];
  end

  always_comb begin
    found = 1'b0;
    off   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        found = 1'b1;
        off   = IDX_W'(k);
      end
    end
  end

  assign win      = wrap_add(start, off);
  assign win_mask = found ? (N'(1) << win) : '0;

endmodule

// File: rtl/ipi_dest_router.sv
module ipi_dest_router
  import ipi_route_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int ID_W    = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ID_W-1:0]         req_dest,
  input  logic                    req_logical,
  input  logic [1:0]              req_short,
  input  logic                    req_lowpri,
  input  logic [IDX_W-1:0]        req_src,
  input  logic [N_UNITS*ID_W-1:0] unit_id,
  input  logic [N_UNITS*ID_W-1:0] unit_lid,
  input  logic [N_UNITS*4-1:0]    unit_fmt,
  input  logic [N_UNITS-1:0]      unit_en,
  output logic                    acc_valid,
  output logic [N_UNITS-1:0]      acc_mask
);

  localparam logic [IDX_W-1:0] PTR_INIT = IDX_W'(N_UNITS - 1);

  logic [N_UNITS-1:0] hit;
  logic [N_UNITS-1:0] cand;
  logic [N_UNITS-1:0] pick_mask;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_found;
  logic [IDX_W-1:0]   rr_ptr;
  short_e             sh;

  assign sh = short_e'(req_short);

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    ipi_match_unit #(
      .ID_W (ID_W),
      .IDX_W(IDX_W),
      .INDEX(i)
    ) match_i (
      .dest     (req_dest),
      .logical  (req_logical),
      .shorthand(sh),
      .src      (req_src),
      .id       (unit_id[i*ID_W +: ID_W]),
      .lid      (unit_lid[i*ID_W +: ID_W]),
      .fmt      (unit_fmt[i*4 +: 4]),
      .hit      (hit[i])
    );
  end

  assign cand = hit & unit_en;

  ipi_rr_pick #(
    .N    (N_UNITS),
    .IDX_W(IDX_W)
  ) pick_i (
    .cand    (cand),
    .prev    (rr_ptr),
    .found   (pick_found),
    .win     (pick_idx),
    .win_mask(pick_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_mask  <= '0;
      rr_ptr    <= PTR_INIT;
    end else begin
      acc_valid <= req_valid;
      if (!req_valid) begin
        acc_mask <= '0;
      end else if (req_lowpri) begin
        acc_mask <= pick_mask;
        if (pick_found) rr_ptr <= pick_idx;
      end else begin
        acc_mask <= hit;
      end
    end
  end

endmodule

// File: rtl/ipi_dest_router_chk.sv
module ipi_dest_router_chk #(
  parameter int N_UNITS = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [1:0]         req_short,
  input logic               req_lowpri,
  input logic [IDX_W-1:0]   req_src,
  input logic [N_UNITS-1:0] unit_en,
  input logic               acc_valid,
  input logic [N_UNITS-1:0] acc_mask
);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!acc_valid && acc_mask == '0));

  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> acc_valid);

  a_r8_single_pick: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lowpri) |=> $onehot0(acc_mask));

  a_r8_pick_enabled: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lowpri) |=> ((acc_mask & ~$past(unit_en)) == '0));

  a_r7_self_only: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_lowpri && req_short == 2'd1) |=>
      ($countones(acc_mask) == 1 && acc_mask[$past(req_src)]));

  a_r7_all_units: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_lowpri && req_short == 2'd2) |=> (&acc_mask));

  a_r7_all_but_src: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_lowpri && req_short == 2'd3) |=>
      ($countones(acc_mask) == N_UNITS - 1 && !acc_mask[$past(req_src)]));

endmodule

bind ipi_dest_router ipi_dest_router_chk #(
  .N_UNITS(N_UNITS),
  .IDX_W  (IDX_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_short (req_short),
  .req_lowpri(req_lowpri),
  .req_src   (req_src),
  .unit_en   (unit_en),
  .acc_valid (acc_valid),
  .acc_mask  (acc_mask)
);

// File: tb/ipi_dest_router_tb_top.sv
module ipi_dest_router_tb_top;

  localparam int N  = 8;
  localparam int IW = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [7:0]     req_dest = '0;
  logic           req_logical = 1'b0;
  logic [1:0]     req_short = '0;
  logic           req_lowpri = 1'b0;
  logic [IW-1:0]  req_src = '0;
  logic [N*8-1:0] unit_id;
  logic [N*8-1:0] unit_lid;
  logic [N*4-1:0] unit_fmt;
  logic [N-1:0]   unit_en;
  logic           acc_valid;
  logic [N-1:0]   acc_mask;

  logic [7:0] cfg_id  [N];
  logic [7:0] cfg_lid [N];
  logic [3:0] cfg_fmt [N];
  logic       cfg_en  [N];

  int n_checks = 0;
  int n_fail   = 0;
  int m_ptr    = N - 1;
  logic done = 1'b0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      unit_id[i*8 +: 8]  = cfg_id[i];
      unit_lid[i*8 +: 8] = cfg_lid[i];
      unit_fmt[i*4 +: 4] = cfg_fmt[i];
      unit_en[i]         = cfg_en[i];
    end
  end

  ipi_dest_router #(.N_UNITS(N), .ID_W(8)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_short(req_short), .req_lowpri(req_lowpri),
    .req_src(req_src), .unit_id(unit_id), .unit_lid(unit_lid),
    .unit_fmt(unit_fmt), .unit_en(unit_en), .acc_valid(acc_valid),
    .acc_mask(acc_mask)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic unit_hit(int i, logic [7:0] d, logic lg, logic [1:0] sh, int src);
    case (sh)
      2'd1: return i == src;
      2'd2: return 1'b1;
      2'd3: return i != src;
      default: begin
        if (!lg) return (d == cfg_id[i]) || (d == 8'hFF);
        if (cfg_fmt[i] == 4'hF) return (cfg_lid[i] & d) != 0;
        if (cfg_fmt[i] == 4'h0)
          return (cfg_lid[i][7:4] == d[7:4]) && ((cfg_lid[i][3:0] & d[3:0]) != 0);
        return 1'b0;
      end
    endcase
  endfunction

  task automatic send(input string tag, input logic [7:0] d, input logic lg,
                      input logic [1:0] sh, input logic lp, input int src);
    logic [N-1:0] exp;
    exp = '0;
    @(negedge clk);
    for (int i = 0; i < N; i++) exp[i] = unit_hit(i, d, lg, sh, src);
    if (lp) begin
      logic [N-1:0] one;
      one = '0;
      for (int k = 1; k <= N; k++) begin
        int idx;
        idx = (m_ptr + k) % N;
        if (exp[idx] && cfg_en[idx] && one == '0) begin
          one[idx] = 1'b1;
          m_ptr = idx;
        end
      end
      exp = one;
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_dest = d; req_logical = lg; req_short = sh;
    req_lowpri = lp; req_src = IW'(src);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && acc_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2: unexpected result %b, expected none", acc_mask);
      end else begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, acc_mask, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      cfg_id[i] = 8'h10 + 8'(i); cfg_lid[i] = 8'(1 << i);
      cfg_fmt[i] = 4'hF; cfg_en[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset valid", N'(acc_valid), '0);
    check("R1 reset mask", acc_mask, '0);

    send("R3 physical id", 8'h13, 1'b0, 2'd0, 1'b0, 0);
    send("R3 physical broadcast", 8'hFF, 1'b0, 2'd0, 1'b0, 0);
    send("R3 physical miss", 8'h55, 1'b0, 2'd0, 1'b0, 0);
    send("R4 flat two units", 8'h05, 1'b1, 2'd0, 1'b0, 0);
    send("R4 flat miss", 8'h00, 1'b1, 2'd0, 1'b0, 0);
    @(negedge clk);
    check("R2 idle after result", N'(acc_valid), '0);

    for (int i = 0; i < N; i++) begin
      cfg_fmt[i] = 4'h0;
      cfg_lid[i] = (i < 4) ? (8'h10 | 8'(1 << i)) : (8'h20 | 8'(1 << (i - 4)));
    end
    send("R5 cluster upper", 8'h23, 1'b1, 2'd0, 1'b0, 0);
    send("R5 cluster lower", 8'h1C, 1'b1, 2'd0, 1'b0, 0);
    send("R5 cluster nibble mismatch", 8'h33, 1'b1, 2'd0, 1'b0, 0);
    cfg_fmt[5] = 4'h5;
    send("R6 odd format", 8'h23, 1'b1, 2'd0, 1'b0, 0);
    cfg_fmt[5] = 4'h0;

    send("R7 self", 8'hFF, 1'b0, 2'd1, 1'b0, 2);
    send("R7 all", 8'h00, 1'b1, 2'd2, 1'b0, 2);
    send("R7 all but src", 8'h12, 1'b0, 2'd3, 1'b0, 2);

    send("R8 first pick", 8'h00, 1'b0, 2'd2, 1'b1, 0);
    send("R8 next pick", 8'h00, 1'b0, 2'd2, 1'b1, 0);
    cfg_en[2] = 1'b0;
    send("R8 skip disabled", 8'h00, 1'b0, 2'd2, 1'b1, 0);
    send("R8 wrap to single", 8'h11, 1'b0, 2'd0, 1'b1, 0);
    send("R9 no candidate", 8'h55, 1'b0, 2'd0, 1'b1, 0);
    send("R9 fixed keeps ptr", 8'h00, 1'b0, 2'd2, 1'b0, 0);
    send("R9 ptr unchanged", 8'h00, 1'b0, 2'd2, 1'b1, 0);
    send("R10 disabled fixed", 8'h12, 1'b0, 2'd0, 1'b0, 0);
    send("R8 all but src pick", 8'h00, 1'b0, 2'd3, 1'b1, 4);
    cfg_en[2] = 1'b1;
    send("R8 wrap around end", 8'h17, 1'b0, 2'd0, 1'b1, 0);
    send("R8 after wrap", 8'h00, 1'b0, 2'd2, 1'b1, 0);

    repeat (3) @(negedge clk);
    check("R2 all results seen", N'(exp_q.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R2: watchdog expired, actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule